// File: doc/BRIEF.md
# Packed SerDes Register Window

This block gives access to the 16-bit configuration registers of 14 SerDes lanes. The registers are packed two to a 32-bit word inside a shared window. A requester presents a lane, a page, a register number, a read/write flag and 16 bits of write data. The block works out which word holds that register, or decides that the location is a hole or out of range. A read returns the selected half-word. A write reads the word, merges the new half with the untouched partner half and writes the whole word back.

Lanes are taken in pairs: each even/odd pair owns a 1024-byte region. Which pages exist depends on the lane's speed class. Lanes 8, 9, 12 and 13 are 10G-class; every other lane is 5G-class. The backing words sit in an internal array that is cleared by a sweep after reset. The block accepts one request at a time and has a fixed latency.

Top module: `serdes_pack_window`

## Requirements
- R1: While reset is held, `err`, `rsp_valid` and `wr_done` are low and `busy` is high. After reset the block clears every storage word, keeping `busy` high, and then drops `busy`. Any mapped register that has not been written reads 0.
- R2: A request with lane 14 or 15, or with page 12 to 15, is out of range. It raises `err` for exactly the one cycle after the accepting edge. It gives no `rsp_valid` and no `wr_done`, and it changes no storage.
- R3: Pages 0 to 3 exist on every lane. The byte offset is `(lane & ~1)*512 + (reg & ~1)*2 + page*64 + (lane & 1)*256`. The even and odd lane of a pair therefore hold separate registers.
- R4: Pages 4 to 7 exist only on lanes 8 and 12, at the base offset plus 256. On every other lane they are holes.
- R5: Pages 8 and 9 exist only on 5G-class lanes, at the base offset plus 256 plus (lane & 1)*128. Pages 10 and 11 exist only on 10G-class lanes, at the base offset plus 128 plus (lane & 1)*128. The base offset is `(lane & ~1)*512 + (reg & ~1)*2 + page*64`, and the word index is the offset divided by 4.
- R6: An even register number lives in bits 15:0 of its word and an odd one in bits 31:16. A write changes only its own half and keeps the partner register (reg ^ 1).
- R7: A read of a hole returns 0 with `rsp_valid`. A write to a hole still pulses `wr_done` but changes no storage.
- R8: On page 2, register 2 reads 0x001C and register 3 reads 0x8393 on every lane, and writes to them do not change what they read.
- R9: For an in-range request accepted at edge E, `rsp_valid` (read) or `wr_done` (write) is high for exactly one cycle, starting at edge E+2. `busy` stays high from edge E until that result. Requests presented while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lane | input | 4 | Lane number |
| req_page | input | 4 | Page number |
| req_reg | input | 5 | Register number 0..31 |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Clearing sweep or request in flight |
| err | output | 1 | One-cycle out-of-range flag |
| rsp_valid | output | 1 | One-cycle read result strobe |
| rsp_rdata | output | 16 | Read data, valid with `rsp_valid` |
| wr_done | output | 1 | One-cycle write completion strobe |

## Verification
Call the edge that takes a request E. The error flag is due one cycle after E, and a read result or write completion is due two cycles after E. The bench drives inputs on falling edges and samples on the falling edge after each of E, E+1 and E+2. At every sample point it checks that the strobe is present exactly where it is due and absent at the others. The data is compared against a word model kept in the bench. A request presented while `busy` is high is checked to be ignored by reading the target location back afterwards.

// File: rtl/sds_win_pkg.sv
package sds_win_pkg;
  localparam int LANE_W       = 4;
  localparam int PAGE_W       = 4;
  localparam int REG_W        = 5;
  localparam int HALF_W       = 16;
  localparam int WORD_W       = 2 * HALF_W;
  localparam int NUM_LANES    = 14;
  localparam int NUM_PAGES    = 12;
  localparam int REGION_BYTES = 1024;
  localparam logic [(1<<LANE_W)-1:0] FAST_LANES = 16'h3300;  // lanes 8,9,12,13
  localparam int WORDS        = (NUM_LANES / 2) * REGION_BYTES / 4;
  localparam int IDX_W        = $clog2(WORDS);
  localparam logic [HALF_W-1:0] ID_LO = 16'h001C;
  localparam logic [HALF_W-1:0] ID_HI = 16'h8393;

  typedef struct packed {
    logic             bad;
    logic             hit;
    logic [IDX_W-1:0] idx;
  } loc_t;

  typedef struct packed {
    logic              wr;
    logic [PAGE_W-1:0] page;
    logic [REG_W-1:0]  rg;
    logic [HALF_W-1:0] data;
    logic              hit;
    logic [IDX_W-1:0]  idx;
  } stage_t;

  function automatic loc_t locate(input logic [LANE_W-1:0] lane,
                                  input logic [PAGE_W-1:0] page,
                                  input logic [REG_W-1:0]  rg);
    loc_t        r;
    int unsigned base;
    int unsigned extra;
    int unsigned pg;
    logic        fast;
    logic        odd;
    pg    = int'(page);
    fast  = FAST_LANES[lane];
    odd   = lane[0];
    base  = ((int'(lane) & 32'hFFFE) << 9) + ((int'(rg) & 32'hFFFE) << 1) + (pg << 6);
    extra = 0;
    r.bad = (int'(lane) >= NUM_LANES) || (pg >= NUM_PAGES);
    if (pg < 4) begin
      r.hit = 1'b1;
      extra = odd ? 256 : 0;
    end else if (pg < 8) begin
      r.hit = fast && !odd;
      extra = 256;
    end else if (pg < 10) begin
      r.hit = !fast;
      extra = 256 + (odd ? 128 : 0);
    end else begin
      r.hit = fast;
      extra = 128 + (odd ? 128 : 0);
    end
    if (r.bad) r.hit = 1'b0;
    r.idx = IDX_W'((base + extra) >> 2);
    return r;
  endfunction

  function automatic logic is_id_reg(input logic [PAGE_W-1:0] page,
                                     input logic [REG_W-1:0]  rg);
    return (page == PAGE_W'(2)) && (rg[REG_W-1:1] == (REG_W-1)'(1));
  endfunction

  function automatic logic [HALF_W-1:0] id_value(input logic [REG_W-1:0] rg);
    return rg[0] ? ID_HI : ID_LO;
  endfunction

  function automatic logic [HALF_W-1:0] pick_half(input logic [WORD_W-1:0] w,
                                                  input logic upper);
    return upper ? w[WORD_W-1:HALF_W] : w[HALF_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] merge_half(input logic [HALF_W-1:0] nw,
                                                   input logic [HALF_W-1:0] keep,
                                                   input logic upper);
    return upper ? {nw, keep} : {keep, nw};
  endfunction
endpackage

// File: rtl/sds_win_decode.sv
module sds_win_decode
  import sds_win_pkg::*;
(
  input  logic [LANE_W-1:0] lane,
  input  logic [PAGE_W-1:0] page,
  input  logic [REG_W-1:0]  rg,
  output loc_t              loc
);
  always_comb loc = locate(lane, page, rg);
endmodule

// File: rtl/sds_win_store.sv
module sds_win_store #(
  parameter int DEPTH = 1792,
  parameter int AW    = 11,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_word,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_word,
  output logic          clearing
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] clr_idx;
  logic          we;
  logic [AW-1:0] widx;
  logic [DW-1:0] wdat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clearing <= 1'b1;
      clr_idx  <= '0;
    end else if (clearing) begin
      clr_idx <= clr_idx + AW'(1);
      if (clr_idx == LAST) clearing <= 1'b0;
    end
  end

  always_comb begin
    we   = clearing | wr_en;
    widx = clearing ? clr_idx : wr_idx;
    wdat = clearing ? '0 : wr_word;
  end

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdat;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_word <= mem[rd_idx];
  end
endmodule

// File: rtl/sds_win_ctrl.sv
module sds_win_ctrl
  import sds_win_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [HALF_W-1:0] req_wdata,
  input  loc_t              loc,
  input  logic              clearing,
  input  logic [WORD_W-1:0] rd_word,
  output logic              st_rd_en,
  output logic [IDX_W-1:0]  st_rd_idx,
  output logic              st_wr_en,
  output logic [IDX_W-1:0]  st_wr_idx,
  output logic [WORD_W-1:0] st_wr_word,
  output logic              busy,
  output logic              err,
  output logic              rsp_valid,
  output logic [HALF_W-1:0] rsp_rdata,
  output logic              wr_done,
  output logic              rd_hole,
  output logic              rd_ident
);
  logic        accept;
  logic        s1_v, s2_v;
  stage_t      s1, s2;
  logic [HALF_W-1:0] own_half, keep_half, rd_val;
  logic        upper;

  assign busy   = clearing | s1_v | s2_v;
  assign accept = req_valid & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
      err  <= 1'b0;
      s1   <= '0;
      s2   <= '0;
    end else begin
      s1_v <= accept & ~loc.bad;
      err  <= accept & loc.bad;
      if (accept) s1 <= '{wr: req_write, page: req_page, rg: req_reg,
                          data: req_wdata, hit: loc.hit, idx: loc.idx};
      s2_v <= s1_v;
      s2   <= s1;
    end
  end

  assign st_rd_en  = s1_v & s1.hit;
  assign st_rd_idx = s1.idx;

  always_comb begin
    upper     = s2.rg[0];
    own_half  = pick_half(rd_word, upper);
    keep_half = is_id_reg(s2.page, s2.rg ^ REG_W'(1)) ? id_value(s2.rg ^ REG_W'(1))
                                                      : pick_half(rd_word, ~upper);
    if (!s2.hit)                    rd_val = '0;
    else if (is_id_reg(s2.page, s2.rg)) rd_val = id_value(s2.rg);
    else                            rd_val = own_half;
  end

  assign st_wr_en   = s2_v & s2.wr & s2.hit;
  assign st_wr_idx  = s2.idx;
  assign st_wr_word = merge_half(s2.data, keep_half, upper);
  assign rd_hole    = s2_v & ~s2.wr & ~s2.hit;
  assign rd_ident   = s2_v & ~s2.wr & s2.hit & is_id_reg(s2.page, s2.rg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      wr_done   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= s2_v & ~s2.wr;
      wr_done   <= s2_v & s2.wr;
      if (s2_v & ~s2.wr) rsp_rdata <= rd_val;
    end
  end
endmodule

// File: rtl/serdes_pack_window.sv
module serdes_pack_window
  import sds_win_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [3:0]  req_lane,
  input  logic [3:0]  req_page,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        err,
  output logic        rsp_valid,
  output logic [15:0] rsp_rdata,
  output logic        wr_done
);
  loc_t              loc;
  logic              clearing;
  logic [WORD_W-1:0] rd_word;
  logic              st_rd_en;
  logic [IDX_W-1:0]  st_rd_idx;
  logic              store_we;
  logic [IDX_W-1:0]  st_wr_idx;
  logic [WORD_W-1:0] st_wr_word;
  logic              rd_hole;
  logic              rd_ident;

  sds_win_decode u_dec (
    .lane(req_lane), .page(req_page), .rg(req_reg), .loc(loc)
  );

  sds_win_store #(.DEPTH(WORDS), .AW(IDX_W), .DW(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_en(st_rd_en), .rd_idx(st_rd_idx), .rd_word(rd_word),
    .wr_en(store_we), .wr_idx(st_wr_idx), .wr_word(st_wr_word),
    .clearing(clearing)
  );

  sds_win_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_page(req_page), .req_reg(req_reg), .req_wdata(req_wdata),
    .loc(loc), .clearing(clearing), .rd_word(rd_word),
    .st_rd_en(st_rd_en), .st_rd_idx(st_rd_idx),
    .st_wr_en(store_we), .st_wr_idx(st_wr_idx), .st_wr_word(st_wr_word),
    .busy(busy), .err(err), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .wr_done(wr_done), .rd_hole(rd_hole), .rd_ident(rd_ident)
  );
endmodule

// File: rtl/sds_win_chk.sv
module sds_win_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        err,
  input logic        rsp_valid,
  input logic [15:0] rsp_rdata,
  input logic        wr_done,
  input logic        store_we,
  input logic        rd_hole,
  input logic        rd_ident
);
  p_err_no_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!rsp_valid && !wr_done));

  p_result_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || wr_done) |-> $past(busy));

  p_single_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && wr_done));

  p_store_then_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    store_we |=> wr_done);

  p_hole_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hole |=> (rsp_valid && rsp_rdata == 16'h0000));

  p_ident_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ident |=> (rsp_valid && (rsp_rdata == 16'h001C || rsp_rdata == 16'h8393)));
endmodule

bind serdes_pack_window sds_win_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .err(err),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .wr_done(wr_done),
  .store_we(store_we), .rd_hole(rd_hole), .rd_ident(rd_ident)
);

// File: tb/sim_serdes_pack_window.sv
`timescale 1ns/1ps
module sim_serdes_pack_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_lane = '0, req_page = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, err, rsp_valid, wr_done;
  logic [15:0] rsp_rdata;

  int n_run = 0, n_fail = 0;
  int cyc = 0;
  bit done = 0;
  logic [31:0] model [0:1791];

  always #5 clk = ~clk;

  serdes_pack_window u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_lane(req_lane), .req_page(req_page), .req_reg(req_reg),
    .req_wdata(req_wdata), .busy(busy), .err(err), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .wr_done(wr_done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Location rules restated per speed class and page band
  function automatic void where(input int lane, input int page, input int rg,
                                output bit bad, output bit hit, output int idx);
    bit fast = (lane == 8) || (lane == 9) || (lane == 12) || (lane == 13);
    int odd  = lane % 2;
    int off  = (lane / 2) * 1024 + (rg / 2) * 4 + page * 64;
    bad = (lane > 13) || (page > 11);
    hit = 0;
    if (!bad) begin
      if (page <= 3)       begin hit = 1;            off += odd * 256; end
      else if (page <= 7)  begin hit = (lane == 8) || (lane == 12); off += 256; end
      else if (page <= 9)  begin hit = !fast;         off += 256 + odd * 128; end
      else                 begin hit = fast;          off += 128 + odd * 128; end
    end
    idx = off / 4;
  endfunction

  function automatic logic [15:0] id_of(input int page, input int rg, output bit is_id);
    is_id = (page == 2) && (rg == 2 || rg == 3);
    return (rg == 3) ? 16'h8393 : 16'h001C;
  endfunction

  function automatic logic [15:0] expect_rd(input int lane, input int page, input int rg);
    bit bad, hit, is_id; int idx; logic [15:0] c;
    where(lane, page, rg, bad, hit, idx);
    c = id_of(page, rg, is_id);
    if (!hit) return 16'h0;
    if (is_id) return c;
    return (rg % 2) ? model[idx][31:16] : model[idx][15:0];
  endfunction

  function automatic void model_wr(input int lane, input int page, input int rg, input logic [15:0] d);
    bit bad, hit, is_id; int idx; logic [15:0] keep, c;
    where(lane, page, rg, bad, hit, idx);
    if (!hit) return;
    c = id_of(page, rg ^ 1, is_id);
    keep = is_id ? c : ((rg % 2) ? model[idx][15:0] : model[idx][31:16]);
    model[idx] = (rg % 2) ? {d, keep} : {keep, d};
  endfunction

  // One request with sampling after E, E+1, E+2
  task automatic xfer(input string tag, input bit wr, input int lane, input int page,
                      input int rg, input logic [15:0] d);
    bit bad, hit; int idx;
    logic e0, b0, s0, e1, s1, rv2, wd2; logic [15:0] dat;
    logic [15:0] exp_d;
    where(lane, page, rg, bad, hit, idx);
    exp_d = expect_rd(lane, page, rg);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_lane = 4'(lane); req_page = 4'(page);
    req_reg = 5'(rg); req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    e0 = err; b0 = busy; s0 = rsp_valid | wr_done;
    @(negedge clk);
    e1 = err; s1 = rsp_valid | wr_done;
    @(negedge clk);
    rv2 = rsp_valid; wd2 = wr_done; dat = rsp_rdata;
    if (bad) begin
      check({tag, " R2 err timing"}, {e0, e1, s0, s1, rv2, wd2}, 6'b100000);
    end else begin
      check({tag, " R9 strobe timing"}, {e0, b0, s0, e1, s1, rv2, wd2},
            {1'b0, 1'b1, 3'b000, ~wr, wr});
      if (!wr) check({tag, " read data"}, 32'(dat), 32'(exp_d));
      else model_wr(lane, page, rg, d);
    end
  endtask

  initial begin
    for (int i = 0; i < 1792; i++) model[i] = 32'h0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {28'h0, err, rsp_valid, wr_done, busy}, 32'h1);
    rst_n = 1;
    begin
      int w = 0;
      while (busy && w < 5000) begin @(negedge clk); w++; end
      check("R1 clear sweep ends", 32'(busy), 32'h0);
    end
    xfer("R1 fresh read", 0, 5, 1, 7, 16'h0);
    xfer("R1 fresh read p9", 0, 2, 9, 30, 16'h0);

    xfer("R3 wr lane0", 1, 0, 1, 4, 16'h1234);
    xfer("R3 wr lane1", 1, 1, 1, 4, 16'hABCD);
    xfer("R3 rd lane0", 0, 0, 1, 4, 16'h0);
    xfer("R3 rd lane1", 0, 1, 1, 4, 16'h0);
    check("R3 lane0 value", 32'(expect_rd(0, 1, 4)), 32'h1234);
    xfer("R6 wr odd", 1, 0, 1, 5, 16'h5555);
    xfer("R6 rd even kept", 0, 0, 1, 4, 16'h0);
    xfer("R6 rd odd", 0, 0, 1, 5, 16'h0);

    xfer("R4 wr lane8 p5", 1, 8, 5, 9, 16'hBEEF);
    xfer("R4 rd lane8 p5", 0, 8, 5, 9, 16'h0);
    xfer("R4 wr lane9 p5", 1, 9, 5, 9, 16'h7777);
    xfer("R4 rd lane9 p5 hole", 0, 9, 5, 9, 16'h0);
    xfer("R4 rd lane0 p4 hole", 0, 0, 4, 0, 16'h0);
    xfer("R4 wr lane12 p7", 1, 12, 7, 31, 16'h0F0F);
    xfer("R4 rd lane12 p7", 0, 12, 7, 31, 16'h0);

    xfer("R5 wr lane3 p9", 1, 3, 9, 12, 16'h3C3C);
    xfer("R5 rd lane3 p9", 0, 3, 9, 12, 16'h0);
    xfer("R5 wr lane9 p9 hole", 1, 9, 9, 12, 16'h9999);
    xfer("R5 rd lane9 p9 hole", 0, 9, 9, 12, 16'h0);
    xfer("R5 wr lane13 p11", 1, 13, 11, 1, 16'hD00D);
    xfer("R5 rd lane13 p11", 0, 13, 11, 1, 16'h0);
    xfer("R7 wr lane2 p10 hole", 1, 2, 10, 0, 16'hFFFF);
    xfer("R7 rd lane2 p10 hole", 0, 2, 10, 0, 16'h0);

    xfer("R2 lane14", 1, 14, 0, 0, 16'h1111);
    xfer("R2 lane15", 0, 15, 3, 3, 16'h0);
    xfer("R2 page12", 1, 0, 12, 4, 16'h2222);
    xfer("R2 page15", 0, 8, 15, 1, 16'h0);
    xfer("R2 storage unchanged", 0, 0, 1, 4, 16'h0);

    xfer("R8 rd id lo", 0, 4, 2, 2, 16'h0);
    xfer("R8 rd id hi", 0, 11, 2, 3, 16'h0);
    xfer("R8 wr id lo", 1, 4, 2, 2, 16'h4444);
    xfer("R8 rd id lo after wr", 0, 4, 2, 2, 16'h0);
    check("R8 id model", 32'(expect_rd(4, 2, 2)), 32'h001C);

    // R9: a request presented while busy must be ignored
    begin
      @(negedge clk);
      req_valid = 1; req_write = 1; req_lane = 4'd6; req_page = 4'd0;
      req_reg = 5'd10; req_wdata = 16'hAAAA;
      @(negedge clk);
      check("R9 busy after accept", 32'(busy), 32'h1);
      req_lane = 4'd7; req_reg = 5'd11; req_wdata = 16'h5A5A;
      @(negedge clk);
      req_valid = 0;
      @(negedge clk);
      check("R9 done at E+2", 32'(wr_done), 32'h1);
      model_wr(6, 0, 10, 16'hAAAA);
      xfer("R9 ignored target", 0, 7, 0, 11, 16'h0);
      check("R9 ignored value", 32'(expect_rd(7, 0, 11)), 32'h0);
      xfer("R9 accepted target", 0, 6, 0, 10, 16'h0);
    end

    void'($urandom(32'd2024));
    for (int k = 0; k < 500; k++) begin
      int ln = $urandom % 16;
      int pg = $urandom % 16;
      int rg = $urandom % 32;
      if (k % 4 != 0) begin ln = ln % 14; pg = pg % 12; end
      if (k % 3 == 0) rg = rg % 6;
      xfer("rnd", ($urandom % 2) == 1, ln, pg, rg, 16'($urandom));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule